// File: doc/BRIEF.md
# Keyed-Unlock Oscillator Control Register

This block is an 8-bit clock-control register on a simple CPU bus. It holds three oscillator enables: internal, crystal and watchdog. It also holds two clock-failure detector enables and a 3-bit system clock source select. Each bit drives a registered output to the clock subsystem. Reads return the stored byte one cycle after the read strobe.

The register is guarded. A data write only takes effect after software writes a two-byte key to the register's own address. After one accepted data write, the register locks again. When the crystal enable is set, a separate registered output takes the two crystal pins away from general-purpose I/O. The block lets software clear every enable at once and does not stop it; only a reset recovers from that state. A status output shows whether the next write to the register will be accepted.

Top module: `clkctl_keyed_reg`

## Requirements
- R1: After reset the stored byte is 0xA0 and the lock status output is low. Therefore internal enable = 1, crystal enable = 0, watchdog enable = 1, both detector enables = 0, clock select = 0 and pin override = 0.
- R2: While locked, a write to address 0xF86 does not change the stored byte, except as a key step.
- R3: A write of 0xE7 to 0xF86, followed by a write of 0x18 to 0xF86, raises the lock status output after the second write's clock edge. The lock status output rises at no other time.
- R4: While unlocked, the next write to 0xF86 stores its data byte. The lock status output is low from the following cycle, and later writes are ignored until the key is given again.
- R5: Key writes (0xE7, 0x18) made while locked never change the stored byte.
- R6: A write to 0xF86 that breaks the key clears the key progress. This is a first byte other than 0xE7, or a second byte other than 0x18 or 0xE7. A second byte of 0xE7 restarts the key, so 0xE7, 0xE7, 0x18 unlocks.
- R7: Writes to any address other than 0xF86 do not change the stored byte, the key progress or the unlocked state.
- R8: A read of 0xF86 returns the stored byte on the read data output in the cycle after the read strobe, whatever the lock state. Reads do not change the key progress or the unlocked state.
- R9: Output mapping of the stored byte:
  - bit 7: internal oscillator enable
  - bit 6: crystal enable
  - bit 5: watchdog oscillator enable
  - bit 4: primary oscillator failure-detect enable
  - bit 3: watchdog oscillator failure-detect enable
  - bits 2:0: clock select
- R10: The crystal pin override output equals the stored crystal enable bit (bit 6).
- R11: An unlocked write of 0x00 is accepted like any other value. It clears every oscillator and detector enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Bus address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after a read of 0xF86 |
| int_osc_en | output | 1 | Internal oscillator enable |
| xtal_osc_en | output | 1 | Crystal oscillator enable |
| wdog_osc_en | output | 1 | Watchdog oscillator enable |
| prim_fail_det_en | output | 1 | Primary oscillator failure-detect enable |
| wdog_fail_det_en | output | 1 | Watchdog oscillator failure-detect enable |
| sys_clk_sel | output | 3 | System clock source select |
| xtal_pin_override | output | 1 | Hands the crystal pins away from GPIO |
| unlocked | output | 1 | High when the next write to the register will be stored |

## Verification
The key sequence is tried in several forms:
- The clean pair 0xE7, 0x18. This tells a working unlock apart from a register that ignores every write.
- A wrong second byte, followed by a lone 0x18. This shows that progress is truly cleared rather than held.
- A doubled first byte. This tells restart handling apart from a plain reset to idle.
- Writes and reads to other addresses placed between the key bytes. These show that only hits on 0xF86 drive the lock sequence.

Data patterns 0x5B, 0xC4 and 0x00 each set a different mix of fields, so a swapped bit, the pin override or a refused all-zero write shows up. A write after every accepted write shows the relock.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

  localparam int CTL_W = 8;

  // bit positions inside the stored control byte
  localparam int BIT_INT_OSC  = 7;
  localparam int BIT_XTAL_OSC = 6;
  localparam int BIT_WDOG_OSC = 5;
  localparam int BIT_PRIM_FD  = 4;
  localparam int BIT_WDOG_FD  = 3;
  localparam int SEL_LSB      = 0;
  localparam int SEL_W        = 3;

  typedef enum logic [1:0] {
    LK_IDLE = 2'd0,
    LK_KEY1 = 2'd1,
    LK_OPEN = 2'd2
  } lock_state_t;

  typedef struct packed {
    logic             int_osc;
    logic             xtal_osc;
    logic             wdog_osc;
    logic             prim_fd;
    logic             wdog_fd;
    logic [SEL_W-1:0] clk_sel;
  } clk_ctl_t;

endpackage

// File: rtl/clkctl_bus_decode.sv
module clkctl_bus_decode #(
  parameter int              ADDR_W   = 12,
  parameter int              DATA_W   = 8,
  parameter logic [11:0]     REG_ADDR = 12'hF86,
  parameter logic [7:0]      KEY_A    = 8'hE7,
  parameter logic [7:0]      KEY_B    = 8'h18
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              wr_hit,
  output logic              rd_hit,
  output logic              key_a_seen,
  output logic              key_b_seen
);

  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REG_ADDR);
  localparam logic [DATA_W-1:0] KA      = DATA_W'(KEY_A);
  localparam logic [DATA_W-1:0] KB      = DATA_W'(KEY_B);

  logic addr_match;

  always_comb begin
    addr_match = (bus_addr == MY_ADDR);
    wr_hit     = bus_wr && addr_match;
    rd_hit     = bus_rd && addr_match;
    key_a_seen = (bus_wdata == KA);
    key_b_seen = (bus_wdata == KB);
  end

endmodule

// File: rtl/clkctl_lock_fsm.sv
module clkctl_lock_fsm
  import clkctl_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wr_hit,
  input  logic key_a_seen,
  input  logic key_b_seen,
  output logic data_wr_en,
  output logic unlocked_q
);

  lock_state_t state_q, state_n;

  always_comb begin
    state_n = state_q;
    if (wr_hit) begin
      unique case (state_q)
        LK_IDLE: state_n = key_a_seen ? LK_KEY1 : LK_IDLE;
        LK_KEY1: begin
          if (key_b_seen)      state_n = LK_OPEN;
          else if (key_a_seen) state_n = LK_KEY1;
          else                 state_n = LK_IDLE;
        end
        LK_OPEN: state_n = LK_IDLE;
        default: state_n = LK_IDLE;
      endcase
    end
  end

  // data is stored only by the write that consumes the open state
  always_comb data_wr_en = wr_hit && (state_q == LK_OPEN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= LK_IDLE;
      unlocked_q <= 1'b0;
    end else begin
      state_q    <= state_n;
      unlocked_q <= (state_n == LK_OPEN);
    end
  end

endmodule

// File: rtl/clkctl_reg_store.sv
module clkctl_reg_store
  import clkctl_pkg::*;
#(
  parameter int         DATA_W    = 8,
  parameter logic [7:0] RESET_VAL = 8'hA0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              data_wr_en,
  input  logic              rd_hit,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata_q,
  output clk_ctl_t          ctl,
  output logic              pin_ovr_q
);

  localparam logic [DATA_W-1:0] RST_V = DATA_W'(RESET_VAL);

  logic [DATA_W-1:0] val_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q     <= RST_V;
      pin_ovr_q <= RST_V[BIT_XTAL_OSC];
      rdata_q   <= '0;
    end else begin
      if (data_wr_en) begin
        val_q     <= wdata;
        pin_ovr_q <= wdata[BIT_XTAL_OSC];
      end
      if (rd_hit) rdata_q <= val_q;
    end
  end

  always_comb begin
    ctl.int_osc  = val_q[BIT_INT_OSC];
    ctl.xtal_osc = val_q[BIT_XTAL_OSC];
    ctl.wdog_osc = val_q[BIT_WDOG_OSC];
    ctl.prim_fd  = val_q[BIT_PRIM_FD];
    ctl.wdog_fd  = val_q[BIT_WDOG_FD];
    ctl.clk_sel  = val_q[SEL_LSB +: SEL_W];
  end

endmodule

// File: rtl/clkctl_keyed_reg.sv
module clkctl_keyed_reg
  import clkctl_pkg::*;
#(
  parameter int         ADDR_W    = 12,
  parameter int         DATA_W    = 8,
  parameter logic [11:0] REG_ADDR = 12'hF86,
  parameter logic [7:0] KEY_A     = 8'hE7,
  parameter logic [7:0] KEY_B     = 8'h18,
  parameter logic [7:0] RESET_VAL = 8'hA0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              int_osc_en,
  output logic              xtal_osc_en,
  output logic              wdog_osc_en,
  output logic              prim_fail_det_en,
  output logic              wdog_fail_det_en,
  output logic [2:0]        sys_clk_sel,
  output logic              xtal_pin_override,
  output logic              unlocked
);

  logic     wr_hit, rd_hit, key_a_seen, key_b_seen, data_wr_en;
  clk_ctl_t ctl;

  clkctl_bus_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR),
    .KEY_A(KEY_A), .KEY_B(KEY_B)
  ) dec_i (
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .wr_hit(wr_hit), .rd_hit(rd_hit),
    .key_a_seen(key_a_seen), .key_b_seen(key_b_seen)
  );

  clkctl_lock_fsm fsm_i (
    .clk(clk), .rst(rst), .wr_hit(wr_hit),
    .key_a_seen(key_a_seen), .key_b_seen(key_b_seen),
    .data_wr_en(data_wr_en), .unlocked_q(unlocked)
  );

  clkctl_reg_store #(
    .DATA_W(DATA_W), .RESET_VAL(RESET_VAL)
  ) store_i (
    .clk(clk), .rst(rst), .data_wr_en(data_wr_en), .rd_hit(rd_hit),
    .wdata(bus_wdata), .rdata_q(bus_rdata), .ctl(ctl),
    .pin_ovr_q(xtal_pin_override)
  );

  always_comb begin
    int_osc_en       = ctl.int_osc;
    xtal_osc_en      = ctl.xtal_osc;
    wdog_osc_en      = ctl.wdog_osc;
    prim_fail_det_en = ctl.prim_fd;
    wdog_fail_det_en = ctl.wdog_fd;
    sys_clk_sel      = ctl.clk_sel;
  end

endmodule

// File: rtl/clkctl_keyed_reg_chk.sv
module clkctl_keyed_reg_chk #(
  parameter int          ADDR_W   = 12,
  parameter int          DATA_W   = 8,
  parameter logic [11:0] REG_ADDR = 12'hF86,
  parameter logic [7:0]  KEY_B    = 8'h18
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              int_osc_en,
  input logic              xtal_osc_en,
  input logic              wdog_osc_en,
  input logic              prim_fail_det_en,
  input logic              wdog_fail_det_en,
  input logic [2:0]        sys_clk_sel,
  input logic              xtal_pin_override,
  input logic              unlocked
);

  logic [7:0] seen_val;
  logic       hit_wr, hit_rd;

  always_comb begin
    seen_val = {int_osc_en, xtal_osc_en, wdog_osc_en,
                prim_fail_det_en, wdog_fail_det_en, sys_clk_sel};
    hit_wr   = bus_wr && (bus_addr == ADDR_W'(REG_ADDR));
    hit_rd   = bus_rd && (bus_addr == ADDR_W'(REG_ADDR));
  end

  assert_locked_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !unlocked |=> $stable(seen_val));

  assert_unlock_by_key_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(unlocked) |-> $past(hit_wr && bus_wdata == DATA_W'(KEY_B)));

  assert_relock_R4: assert property (@(posedge clk) disable iff (rst)
    (unlocked && hit_wr) |=> !unlocked);

  assert_foreign_write_R7: assert property (@(posedge clk) disable iff (rst)
    (unlocked && bus_wr && !hit_wr) |=> unlocked);

  assert_read_data_R8: assert property (@(posedge clk) disable iff (rst)
    hit_rd |=> (bus_rdata == $past(seen_val)));

  assert_pin_override_R10: assert property (@(posedge clk) disable iff (rst)
    xtal_pin_override == xtal_osc_en);

endmodule

bind clkctl_keyed_reg clkctl_keyed_reg_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR), .KEY_B(KEY_B)
) chk_i (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .int_osc_en(int_osc_en), .xtal_osc_en(xtal_osc_en),
  .wdog_osc_en(wdog_osc_en), .prim_fail_det_en(prim_fail_det_en),
  .wdog_fail_det_en(wdog_fail_det_en), .sys_clk_sel(sys_clk_sel),
  .xtal_pin_override(xtal_pin_override), .unlocked(unlocked)
);

// File: tb/clkctl_keyed_reg_tb_top.sv
module clkctl_keyed_reg_tb_top;

  localparam logic [11:0] RADDR = 12'hF86;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        int_osc_en, xtal_osc_en, wdog_osc_en;
  logic        prim_fail_det_en, wdog_fail_det_en;
  logic [2:0]  sys_clk_sel;
  logic        xtal_pin_override, unlocked;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model, written from the requirements
  logic [7:0] mdl_val  = 8'hA0;
  int         mdl_step = 0;  // 0 idle, 1 first key seen, 2 open

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;  // 125 MHz

  clkctl_keyed_reg dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .int_osc_en(int_osc_en), .xtal_osc_en(xtal_osc_en),
    .wdog_osc_en(wdog_osc_en), .prim_fail_det_en(prim_fail_det_en),
    .wdog_fail_det_en(wdog_fail_det_en), .sys_clk_sel(sys_clk_sel),
    .xtal_pin_override(xtal_pin_override), .unlocked(unlocked)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_wr(input logic [11:0] a, input logic [7:0] d);
    if (a != RADDR) return;
    case (mdl_step)
      0: mdl_step = (d == 8'hE7) ? 1 : 0;
      1: mdl_step = (d == 8'h18) ? 2 : ((d == 8'hE7) ? 1 : 0);
      default: begin mdl_val = d; mdl_step = 0; end
    endcase
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    model_wr(a, d);
  endtask

  // driver: pushes the expected read value into the scoreboard
  task automatic rd(input string tag);
    @(negedge clk);
    bus_addr = RADDR; bus_rd = 1'b1;
    exp_q.push_back(mdl_val);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // monitor: pops and compares read data one cycle after the strobe
  initial begin
    forever begin
      @(posedge clk);
      if (bus_rd && bus_addr == RADDR && !rst) begin
        #1;
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R8 actual=%0h expected=none", bus_rdata);
        end else begin
          check(tag_q.pop_front(), {24'd0, bus_rdata}, {24'd0, exp_q.pop_front()});
        end
      end
    end
  end

  task automatic check_outs(input string req);
    check({req, " fields"},
          {24'd0, int_osc_en, xtal_osc_en, wdog_osc_en, prim_fail_det_en,
           wdog_fail_det_en, sys_clk_sel}, {24'd0, mdl_val});
    check({req, " override"}, {31'd0, xtal_pin_override}, {31'd0, mdl_val[6]});
    check({req, " lock"}, {31'd0, unlocked}, {31'd0, mdl_step == 2});
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset value and R9 field mapping of 0xA0
    check("R1 reset byte", {24'd0, int_osc_en, xtal_osc_en, wdog_osc_en,
          prim_fail_det_en, wdog_fail_det_en, sys_clk_sel}, 32'hA0);
    check("R1 locked", {31'd0, unlocked}, 32'd0);
    check("R1 override", {31'd0, xtal_pin_override}, 32'd0);
    rd("R1 R8 read reset");

    // R2: locked write ignored
    wr(RADDR, 8'h55);
    check_outs("R2 locked write");
    rd("R2 read");

    // R3/R5: key unlocks, key bytes not stored
    wr(RADDR, 8'hE7);
    check_outs("R5 after first key");
    wr(RADDR, 8'h18);
    check("R3 unlocked", {31'd0, unlocked}, 32'd1);
    check_outs("R5 after second key");

    // R4/R9/R10: store 0x5B, relock
    wr(RADDR, 8'h5B);
    check_outs("R9 R10 value 5B");
    check("R4 relocked", {31'd0, unlocked}, 32'd0);
    wr(RADDR, 8'h00);
    check_outs("R4 write after relock");
    rd("R4 read 5B");

    // R6: wrong second byte clears progress
    wr(RADDR, 8'hE7);
    wr(RADDR, 8'h19);
    wr(RADDR, 8'h18);
    check("R6 broken key", {31'd0, unlocked}, 32'd0);
    wr(RADDR, 8'h18);  // lone second key byte
    check("R6 wrong first byte", {31'd0, unlocked}, 32'd0);
    wr(RADDR, 8'hE7);
    wr(RADDR, 8'hE7);
    wr(RADDR, 8'h18);
    check("R6 restart E7 E7 18", {31'd0, unlocked}, 32'd1);
    wr(RADDR, 8'hC4);
    check_outs("R6 R9 value C4");

    // R7: foreign writes between key bytes and while open
    wr(RADDR, 8'hE7);
    wr(12'hF87, 8'h18);
    wr(12'h000, 8'hFF);
    wr(RADDR, 8'h18);
    check("R7 key across foreign writes", {31'd0, unlocked}, 32'd1);
    wr(12'hF85, 8'h77);
    check("R7 open kept", {31'd0, unlocked}, 32'd1);
    check_outs("R7 value kept");
    // R11: all-zero accepted
    wr(RADDR, 8'h00);
    check_outs("R11 zero stored");
    rd("R11 read zero");

    // R8: reads do not disturb the key
    wr(RADDR, 8'hE7);
    rd("R8 read mid key");
    wr(RADDR, 8'h18);
    check("R8 read kept key", {31'd0, unlocked}, 32'd1);
    rd("R8 read while open");
    check("R8 read kept open", {31'd0, unlocked}, 32'd1);
    wr(RADDR, 8'h7A);
    check_outs("R8 R9 value 7A");
    rd("R8 read 7A");

    // R1: reset while open
    wr(RADDR, 8'hE7);
    wr(RADDR, 8'h18);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    mdl_val = 8'hA0; mdl_step = 0;
    check_outs("R1 reset while open");

    repeat (3) @(negedge clk);
    check("R8 scoreboard drained", exp_q.size(), 32'd0);
    finish_run();
  end

endmodule